// File: doc/BRIEF.md
# Triggered Dual-Rate Capture Sequencer

This block waits for the rising edge of an asynchronous, very short trigger pulse, sampled in the fast system clock domain. It answers each accepted edge the same way. It runs one cycle of resynchronisation, which clears two clock-enable dividers together. It then opens a capture window on two ADC sample streams that run at different rates. Each divider produces the sample strobe for its converter. During the window, each channel takes exactly its configured number of samples on its own strobe. Each sample goes out as a one-cycle valid pulse with its data word, and the final sample carries a last flag.

The dividers restart on every accepted trigger, so the number of cycles from trigger to first sample is the same every time. It does not depend on where the free-running strobes happened to be. While a window is open, further trigger edges are dropped and raise a sticky overrun flag. A configuration write pulse clears that flag. With the default parameters (100 MHz clock, divide by 50 and by 5, 2000 and 20000 samples), both channels fill a 1 ms window.

Top module: `cap_seq`

## Requirements
- R1: While reset is held and right after it, busy, overrun and all valid and last outputs are 0.
- R2: The trigger passes two synchroniser flops, and only a 0-to-1 change starts a capture. A trigger that is high at one clock edge and low at the next still starts a capture. Busy goes high 3 cycles after the first clock edge that sees the trigger high.
- R3: In the single resynchronisation cycle, both dividers are cleared together, and neither strobe fires in the following cycle.
- R4: Channel 0 takes exactly N0 samples, DIV0 cycles apart. The first valid appears DIV0+4 cycles after the first clock edge that sees the trigger. Each data word is the input present at the clock edge that takes it.
- R5: Channel 1 takes exactly N1 samples, DIV1 cycles apart. The first valid appears DIV1+4 cycles after the first clock edge that sees the trigger. Its data is taken the same way as on channel 0.
- R6: Each channel raises its last flag only together with its final valid sample.
- R7: Busy stays high until both channels have finished, and falls one cycle after the later of the two last samples.
- R8: A trigger edge that arrives while busy is high adds no samples and does not lengthen the window. It sets the overrun flag, and the flag stays set until it is cleared.
- R9: A one-cycle pulse on the overrun clear input resets the overrun flag, effective at the next clock edge.
- R10: The trigger-to-first-sample latency of R4 and R5 stays the same whatever the phase of the free-running dividers when the trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_async_i | input | 1 | Asynchronous external trigger |
| ovr_clr_i | input | 1 | Configuration write pulse that clears overrun |
| ch0_din_i | input | W | Channel 0 ADC data |
| ch1_din_i | input | W | Channel 1 ADC data |
| ch0_ce_o | output | 1 | Channel 0 sample strobe (one cycle in DIV0) |
| ch1_ce_o | output | 1 | Channel 1 sample strobe (one cycle in DIV1) |
| ch0_vld_o | output | 1 | Channel 0 sample valid |
| ch0_dout_o | output | W | Channel 0 captured sample |
| ch0_last_o | output | 1 | Channel 0 final sample of the window |
| ch1_vld_o | output | 1 | Channel 1 sample valid |
| ch1_dout_o | output | W | Channel 1 captured sample |
| ch1_last_o | output | 1 | Channel 1 final sample of the window |
| busy_o | output | 1 | Capture sequence in progress |
| ovr_o | output | 1 | Sticky overrun: trigger seen while busy |

## Verification
Call clock edge A1 the first edge that sees the trigger high. The trigger then crosses two synchroniser flops and the previous-value flop, so busy is due at A3. Sample k of a channel with divider D is taken at A(4+D+k·D) and is visible after that edge. The final samples of both channels land together, so busy is due to fall one edge later. The bench's driver task records the negedge index at which it raises the trigger. From that index it queues the exact cycle, data word and last flag of every sample. The monitor compares each valid against the head of its channel's queue half a period after the producing edge. Busy and overrun are sampled at the precomputed indices, one cycle before and at each transition. Triggers land at several divider phases to show that the latency does not change.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RESYNC = 2'd1,
    ST_ACQ    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/trig_edge.sv
module trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/ce_div.sv
module ce_div #(
  parameter int DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic ce_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)             cnt_d = '0;
    else if (cnt_q == TOP) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign ce_o = (cnt_q == TOP);
endmodule

// File: rtl/chan_cap.sv
module chan_cap #(
  parameter int W  = 12,
  parameter int NS = 2000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         act_i,
  input  logic         ce_i,
  input  logic [W-1:0] din_i,
  output logic         vld_o,
  output logic [W-1:0] dout_o,
  output logic         last_o,
  output logic         done_o
);
  localparam int CW = (NS > 1) ? $clog2(NS) : 1;
  localparam logic [CW-1:0] FINAL = CW'(NS - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          take;
  logic          at_end;

  assign take   = act_i & ce_i & ~done_q;
  assign at_end = (cnt_q == FINAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      if (at_end) done_q <= 1'b1;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      last_o <= 1'b0;
      dout_o <= '0;
    end else begin
      vld_o  <= take;
      last_o <= take & at_end;
      if (take) dout_o <= din_i;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/cap_seq.sv
module cap_seq
  import cap_pkg::*;
#(
  parameter int W    = 12,
  parameter int DIV0 = 50,
  parameter int DIV1 = 5,
  parameter int N0   = 2000,
  parameter int N1   = 20000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         trig_async_i,
  input  logic         ovr_clr_i,
  input  logic [W-1:0] ch0_din_i,
  input  logic [W-1:0] ch1_din_i,
  output logic         ch0_ce_o,
  output logic         ch1_ce_o,
  output logic         ch0_vld_o,
  output logic [W-1:0] ch0_dout_o,
  output logic         ch0_last_o,
  output logic         ch1_vld_o,
  output logic [W-1:0] ch1_dout_o,
  output logic         ch1_last_o,
  output logic         busy_o,
  output logic         ovr_o
);
  localparam int NCH = 2;
  localparam int DIV_A [NCH] = '{DIV0, DIV1};
  localparam int NS_A  [NCH] = '{N0, N1};

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic trig_rise;
  trig_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .async_i(trig_async_i),
    .rise_o (trig_rise)
  );

  seq_state_e state_q, state_d;
  logic       div_clr, acq_on, all_done;
  logic       ovr_q, ovr_d;

  logic         ce   [NCH];
  logic [W-1:0] din  [NCH];
  logic         vld  [NCH];
  logic [W-1:0] dout [NCH];
  logic         last [NCH];
  logic         done [NCH];

  assign din[0] = ch0_din_i;
  assign din[1] = ch1_din_i;

  assign div_clr  = (state_q == ST_RESYNC);
  assign acq_on   = (state_q == ST_ACQ);
  assign all_done = done[0] & done[1];

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (trig_rise) state_d = ST_RESYNC;
      ST_RESYNC: state_d = ST_ACQ;
      ST_ACQ:    if (all_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (trig_rise && (state_q != ST_IDLE)) ovr_d = 1'b1;
    else if (ovr_clr_i)                    ovr_d = 1'b0;
    else                                   ovr_d = ovr_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      state_q <= ST_IDLE;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ovr_q   <= ovr_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ce_div #(.DIV(DIV_A[g])) i_div (
      .clk_i (clk_i),
      .rst_ni(rst_n_q),
      .clr_i (div_clr),
      .ce_o  (ce[g])
    );

    chan_cap #(.W(W), .NS(NS_A[g])) i_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_n_q),
      .start_i(div_clr),
      .act_i  (acq_on),
      .ce_i   (ce[g]),
      .din_i  (din[g]),
      .vld_o  (vld[g]),
      .dout_o (dout[g]),
      .last_o (last[g]),
      .done_o (done[g])
    );
  end

  assign ch0_ce_o   = ce[0];
  assign ch1_ce_o   = ce[1];
  assign ch0_vld_o  = vld[0];
  assign ch0_dout_o = dout[0];
  assign ch0_last_o = last[0];
  assign ch1_vld_o  = vld[1];
  assign ch1_dout_o = dout[1];
  assign ch1_last_o = last[1];
  assign busy_o     = (state_q != ST_IDLE);
  assign ovr_o      = ovr_q;
endmodule

// File: rtl/cap_seq_chk.sv
module cap_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic rise,
  input logic clr,
  input logic busy,
  input logic ovr,
  input logic ovr_clr,
  input logic ce0,
  input logic ce1,
  input logic vld0,
  input logic vld1,
  input logic last0,
  input logic last1
);
  AST_BUSY_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !busy) |=> busy); // R2
  AST_RESYNC_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ce0 && !ce1 && busy)); // R3
  AST_VALID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (vld0 || vld1) |-> busy); // R4
  AST_LAST0_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last0 |-> vld0); // R6
  AST_LAST1_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last1 |-> vld1); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && busy) |=> ovr); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !(rise && busy)) |=> !ovr); // R9
endmodule

bind cap_seq cap_seq_chk i_chk (
  .clk    (clk_i),
  .rst_n  (rst_n_q),
  .rise   (trig_rise),
  .clr    (div_clr),
  .busy   (busy_o),
  .ovr    (ovr_o),
  .ovr_clr(ovr_clr_i),
  .ce0    (ch0_ce_o),
  .ce1    (ch1_ce_o),
  .vld0   (ch0_vld_o),
  .vld1   (ch1_vld_o),
  .last0  (ch0_last_o),
  .last1  (ch1_last_o)
);

// File: tb/test_cap_seq.sv
module test_cap_seq;
  localparam int W    = 12;
  localparam int DIV0 = 10;
  localparam int DIV1 = 2;
  localparam int N0   = 8;
  localparam int N1   = 40;
  localparam int WIN  = DIV0 * N0;

  typedef struct packed {
    int           cyc;
    logic [W-1:0] d;
    logic         l;
  } exp_t;

  logic         clk, rst_n, trig, ovr_clr;
  logic [W-1:0] d0, d1;
  logic         ce0, ce1, v0, v1, l0, l1, busy, ovr;
  logic [W-1:0] q0, q1;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  exp_t q_ch0 [$];
  exp_t q_ch1 [$];

  cap_seq #(.W(W), .DIV0(DIV0), .DIV1(DIV1), .N0(N0), .N1(N1)) i_cap_seq (
    .clk_i(clk), .rst_ni(rst_n), .trig_async_i(trig), .ovr_clr_i(ovr_clr),
    .ch0_din_i(d0), .ch1_din_i(d1), .ch0_ce_o(ce0), .ch1_ce_o(ce1),
    .ch0_vld_o(v0), .ch0_dout_o(q0), .ch0_last_o(l0),
    .ch1_vld_o(v1), .ch1_dout_o(q1), .ch1_last_o(l1),
    .busy_o(busy), .ovr_o(ovr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] f0(int c);
    return W'(c) ^ 12'hA5A;
  endfunction
  function automatic logic [W-1:0] f1(int c);
    return ~W'(c);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // cycle counter, sample drivers and scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    cyc = cyc + 1;
    if (v0) begin
      if (q_ch0.size() == 0) chk(0, "R4 extra ch0 sample", int'(q0), -1);
      else begin
        e = q_ch0.pop_front();
        chk(cyc == e.cyc, "R4 ch0 sample cycle", cyc, e.cyc);
        chk(q0 == e.d, "R4 ch0 data", int'(q0), int'(e.d));
        chk(l0 == e.l, "R6 ch0 last", int'(l0), int'(e.l));
      end
    end else if (l0) chk(0, "R6 ch0 last without valid", 1, 0);
    if (v1) begin
      if (q_ch1.size() == 0) chk(0, "R5 extra ch1 sample", int'(q1), -1);
      else begin
        e = q_ch1.pop_front();
        chk(cyc == e.cyc, "R5 ch1 sample cycle", cyc, e.cyc);
        chk(q1 == e.d, "R5 ch1 data", int'(q1), int'(e.d));
        chk(l1 == e.l, "R6 ch1 last", int'(l1), int'(e.l));
      end
    end else if (l1) chk(0, "R6 ch1 last without valid", 1, 0);
    d0 <= f0(cyc);
    d1 <= f1(cyc);
  end

  task automatic wait_to(input int c);
    while (cyc < c) begin
      @(negedge clk);
      #1;
    end
  endtask

  // driver: one-cycle trigger pulse; queues every expected sample (R10: any phase)
  task automatic fire(output int m);
    @(negedge clk); #1;
    m = cyc;
    trig = 1'b1;
    for (int i = 0; i < N0; i++)
      q_ch0.push_back('{m + 4 + DIV0 + i * DIV0, f0(m + 3 + DIV0 + i * DIV0), i == N0 - 1});
    for (int i = 0; i < N1; i++)
      q_ch1.push_back('{m + 4 + DIV1 + i * DIV1, f1(m + 3 + DIV1 + i * DIV1), i == N1 - 1});
    @(negedge clk); #1;
    trig = 1'b0;
  endtask

  task automatic stray_pulse(output int m);
    @(negedge clk); #1;
    m = cyc;
    trig = 1'b1;
    @(negedge clk); #1;
    trig = 1'b0;
  endtask

  task automatic finish_run();
    chk(q_ch0.size() == 0, "R4 ch0 sample count", q_ch0.size(), 0);
    chk(q_ch1.size() == 0, "R5 ch1 sample count", q_ch1.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    int m, s;
    rst_n = 1'b0; trig = 1'b0; ovr_clr = 1'b0;
    d0 = '0; d1 = '0;
    wait_to(4);
    chk(busy == 0 && ovr == 0, "R1 reset busy/ovr", {busy, ovr}, 0);
    chk(v0 == 0 && v1 == 0 && l0 == 0 && l1 == 0, "R1 reset valid/last", {v0, v1, l0, l1}, 0);
    rst_n = 1'b1;
    wait_to(10);
    chk(busy == 0 && ovr == 0 && v0 == 0 && v1 == 0, "R1 after reset", {busy, ovr, v0, v1}, 0);

    // capture 1
    fire(m);
    wait_to(m + 2); chk(busy == 0, "R2 busy before due", busy, 0);
    wait_to(m + 3); chk(busy == 1, "R2 busy due", busy, 1);
    wait_to(m + 4 + WIN); chk(busy == 1, "R7 busy through last sample", busy, 1);
    wait_to(m + 5 + WIN); chk(busy == 0, "R7 busy falls", busy, 0);
    chk(q_ch0.size() == 0 && q_ch1.size() == 0, "R4 R5 window complete", q_ch0.size() + q_ch1.size(), 0);

    // capture 2 at a different divider phase, stray trigger inside the window
    wait_to(m + WIN + 8);
    fire(m);
    wait_to(m + 20);
    stray_pulse(s);
    wait_to(s + 2); chk(ovr == 0, "R8 ovr before stray edge", ovr, 0);
    wait_to(s + 3); chk(ovr == 1, "R8 ovr set by stray edge", ovr, 1);
    wait_to(m + 4 + WIN); chk(busy == 1, "R8 window unchanged", busy, 1);
    wait_to(m + 5 + WIN); chk(busy == 0, "R8 window not extended", busy, 0);
    chk(ovr == 1, "R8 ovr sticky", ovr, 1);

    // overrun clear
    wait_to(m + WIN + 11);
    ovr_clr = 1'b1;
    @(negedge clk); #1;
    ovr_clr = 1'b0;
    chk(ovr == 0, "R9 ovr cleared", ovr, 0);
    wait_to(cyc + 3);
    chk(busy == 0 && v0 == 0, "R9 clear starts nothing", {busy, v0}, 0);

    // captures 3 and 4 at further phases (R10)
    wait_to(cyc + 7);
    fire(m);
    wait_to(m + 5 + WIN); chk(busy == 0, "R10 capture 3 ends on time", busy, 0);
    wait_to(m + WIN + 13);
    fire(m);
    wait_to(m + 5 + WIN); chk(busy == 0, "R10 capture 4 ends on time", busy, 0);
    chk(ovr == 0, "R8 no overrun without stray edge", ovr, 0);
    wait_to(cyc + 5);
    finish_run();
  end

  initial begin
    while (cyc < 20000) @(negedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule